// File: doc/BRIEF.md
# NAND Flash Register Bridge

This block lets a processor drive an 8-bit asynchronous NAND flash through a 32-bit register port. Every host write carries a packed word: an operation code, a chip-enable request and one data byte. The bridge turns a command, address or data-write operation into exactly one strobed bus cycle on the flash pins. It generates the write-enable pulse with parameterised setup, low and hold timing.

Writing the read operation code puts the bridge into a sticky read mode. From then on, each host read of the data port runs one read-enable pulse on the flash bus and returns the captured byte. Read mode ends when any other operation code is written.

A host read of the control port returns the flash ready/busy state, taken through a two-stage synchroniser. The host port uses a request/acknowledge handshake: the host holds its request until the bridge acknowledges it. The acknowledge comes at once for operations that need no bus cycle, and at the end of the strobe for operations that do.

Top module: `nand_bridge`

## Requirements
- R1: While and after reset, until the first operation: nand_ce_n, nand_we_n and nand_re_n are high; nand_cle, nand_ale and nand_dq_oe are low; host_ack is low.
- R2: A write whose word has bits 30:28 = 0 runs one write-enable pulse with nand_cle high, nand_ale low and nand_dq_oe high. During that pulse nand_dq_o carries bits 23:16 of the word.
- R3: A write with bits 30:28 = 1 runs one write-enable pulse with nand_ale high, nand_cle low, and bits 23:16 of the word on nand_dq_o.
- R4: A write with bits 30:28 = 3 runs one write-enable pulse with nand_cle and nand_ale both low, and bits 23:16 of the word on nand_dq_o.
- R5: Every accepted write loads the chip-enable flag from bit 31 of the word. nand_ce_n is low while that flag is 1 and high while it is 0.
- R6: A write with bits 30:28 = 2 produces no strobe and enters read mode. In read mode, each host read of the data port (host_sel = 1) runs one read-enable pulse. No write-enable pulse occurs and nand_dq_oe stays low. The read returns the captured byte in bits 23:16 of host_rdata, with all other bits zero.
- R7: Read mode stays in force until a write with any other operation code is accepted. A data-port read outside read mode returns zero, is acknowledged in the same cycle, and causes no strobe.
- R8: Writes with bits 30:28 = 4 to 7 cause no write-enable or read-enable pulse and are acknowledged in the same cycle.
- R9: A control-port read (host_sel = 0) returns bit 15 = 1 when the synchronised nand_rb_n is low, and 0 otherwise, with all other bits zero. A change on nand_rb_n first appears after two clock edges.
- R10: A bus cycle has three phases. First, one setup cycle with the strobe high. Then the strobe is low for PULSE_CYC cycles. Then the strobe is high for HOLD_CYC cycles. nand_cle, nand_ale and nand_dq_o do not change from the setup cycle through the hold phase. On a read, the byte is captured at the last clock edge of the low phase.
- R11: host_ack is asserted for one cycle and only while host_req is high. An operation with a bus cycle is acknowledged in the last hold cycle, 1+PULSE_CYC+HOLD_CYC cycles after the request is first presented to an idle bridge. An operation without a bus cycle is acknowledged in the cycle the request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host request, held until host_ack |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | Read target: 0 = control/status port, 1 = data port |
| host_wdata | input | 32 | Packed operation word (bit 31 chip enable, 30:28 operation, 23:16 byte) |
| host_ack | output | 1 | Request completed |
| host_rdata | output | 32 | Read result, valid while host_ack is high |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data driven to the flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_o |
| nand_dq_i | input | 8 | Data from the flash |
| nand_rb_n | input | 1 | Ready/busy from the flash, low = busy |

## Verification
The command, address and data-write codes are each swept over all 256 byte values, with the chip-enable bit alternating. This separates the three latch-enable encodings and exposes any bit slip in the data field. The read code is followed by a data read for every byte value, which shows that each read launches its own strobe and places the byte at bits 23:16. The unused codes 4 to 7 are then written, followed by a data read, to show that they cause no strobe and end read mode. A busy pulse on the ready/busy line is sampled one and two edges later to confirm the synchroniser depth.

// File: rtl/nfb_pkg.sv
package nfb_pkg;

    typedef logic [2:0] op_t;

    localparam op_t OP_CMD   = 3'd0;
    localparam op_t OP_ADDR  = 3'd1;
    localparam op_t OP_READ  = 3'd2;
    localparam op_t OP_WRITE = 3'd3;

    localparam int OP_LSB   = 28;
    localparam int CE_BIT   = 31;
    localparam int BYTE_LSB = 16;
    localparam int BUSY_BIT = 15;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_HOLD
    } phase_t;

    // Fields held on the flash pins between operations
    typedef struct packed {
        logic       ce;
        logic       cle;
        logic       ale;
        logic [7:0] dout;
    } pins_t;

    function automatic logic op_drives_bus(op_t op);
        return (op == OP_CMD) || (op == OP_ADDR) || (op == OP_WRITE);
    endfunction

endpackage

// File: rtl/nfb_rb_sync.sv
module nfb_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/nfb_strobe_seq.sv
module nfb_strobe_seq
    import nfb_pkg::*;
#(
    parameter int PULSE_CYC = 2,
    parameter int HOLD_CYC  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic strobe_low,
    output logic capture,
    output logic done
);
    localparam int MAXC = (PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    phase_t        ph_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE:  if (start) ph_q <= PH_SETUP;
                PH_SETUP: begin
                    ph_q  <= PH_LOW;
                    cnt_q <= CW'(PULSE_CYC - 1);
                end
                PH_LOW: begin
                    if (cnt_q == '0) begin
                        ph_q  <= PH_HOLD;
                        cnt_q <= CW'(HOLD_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt_q == '0) ph_q <= PH_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign busy       = (ph_q != PH_IDLE);
    assign strobe_low = (ph_q == PH_LOW);
    assign capture    = (ph_q == PH_LOW) && (cnt_q == '0);
    assign done       = (ph_q == PH_HOLD) && (cnt_q == '0);

    // R10: no new start is honoured while a cycle is in flight
    a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
endmodule

// File: rtl/nand_bridge.sv
module nand_bridge
    import nfb_pkg::*;
#(
    parameter int PULSE_CYC   = 2,
    parameter int HOLD_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_req,
    input  logic        host_wr,
    input  logic        host_sel,
    input  logic [31:0] host_wdata,
    output logic        host_ack,
    output logic [31:0] host_rdata,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dq_o,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_i,
    input  logic        nand_rb_n
);
    localparam int WCW = $clog2(PULSE_CYC + 2);

    logic  seq_busy, seq_low, seq_cap, seq_done;
    logic  rb_sync;
    pins_t pins_q;
    logic  rd_mode_q, cur_rd_q;
    logic [7:0] rd_byte_q;

    op_t  op;
    logic accept, wr_acc, bus_wr, bus_rd, start, imm_ack;
    logic unused_fields;

    assign op            = host_wdata[OP_LSB +: 3];
    assign unused_fields = ^{host_wdata[27:24], host_wdata[15:0]};

    assign accept  = host_req && !seq_busy;
    assign wr_acc  = accept && host_wr;
    assign bus_wr  = wr_acc && op_drives_bus(op);
    assign bus_rd  = accept && !host_wr && host_sel && rd_mode_q;
    assign start   = bus_wr || bus_rd;
    assign imm_ack = accept && !start;

    nfb_strobe_seq #(.PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .busy       (seq_busy),
        .strobe_low (seq_low),
        .capture    (seq_cap),
        .done       (seq_done)
    );

    nfb_rb_sync #(.STAGES(SYNC_STAGES)) u_rb (
        .clk      (clk),
        .rst      (rst),
        .async_in (nand_rb_n),
        .sync_out (rb_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q    <= '0;
            rd_mode_q <= 1'b0;
            cur_rd_q  <= 1'b0;
            rd_byte_q <= '0;
        end else begin
            if (wr_acc) begin
                pins_q.ce  <= host_wdata[CE_BIT];
                pins_q.cle <= (op == OP_CMD);
                pins_q.ale <= (op == OP_ADDR);
                rd_mode_q  <= (op == OP_READ);
                if (op_drives_bus(op))
                    pins_q.dout <= host_wdata[BYTE_LSB +: 8];
            end
            if (start)
                cur_rd_q <= bus_rd;
            if (seq_cap && cur_rd_q)
                rd_byte_q <= nand_dq_i;
        end
    end

    assign nand_ce_n  = !pins_q.ce;
    assign nand_cle   = pins_q.cle;
    assign nand_ale   = pins_q.ale;
    assign nand_dq_o  = pins_q.dout;
    assign nand_we_n  = !(seq_low && !cur_rd_q);
    assign nand_re_n  = !(seq_low && cur_rd_q);
    assign nand_dq_oe = seq_busy && !cur_rd_q;

    assign host_ack = imm_ack || seq_done;

    always_comb begin
        host_rdata = '0;
        if (!host_wr) begin
            if (!host_sel)
                host_rdata[BUSY_BIT] = !rb_sync;
            else if (rd_mode_q)
                host_rdata[BYTE_LSB +: 8] = rd_byte_q;
        end
    end

    // Strobe low-time counters for the width checks
    logic [WCW-1:0] wlow_q, rlow_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            wlow_q <= '0;
            rlow_q <= '0;
        end else begin
            wlow_q <= nand_we_n ? '0 : wlow_q + 1'b1;
            rlow_q <= nand_re_n ? '0 : rlow_q + 1'b1;
        end
    end

    a_r10_we_width: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |-> (wlow_q == WCW'(PULSE_CYC)));
    a_r10_re_width: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_re_n) |-> (rlow_q == WCW'(PULSE_CYC)));
    a_r10_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(nand_we_n) |-> ($stable(nand_cle) && $stable(nand_ale)
                              && $stable(nand_dq_o) && $past(nand_dq_oe)));
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |=> ($stable(nand_cle) && $stable(nand_ale)
                              && $stable(nand_dq_o)));
    a_r8_unused_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && op[2]) |=> (nand_we_n && nand_re_n));
    a_r6_read_no_we: assert property (@(posedge clk) disable iff (rst)
        rd_mode_q |-> nand_we_n);
    a_r11_ack_req: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> host_req);
endmodule

// File: tb/tb_nand_bridge.sv
module tb_nand_bridge;
    localparam int P = 2;
    localparam int H = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_wr = 1'b0, host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_o;
    logic [7:0]  nand_dq_i = '0;
    logic        nand_rb_n = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    nand_bridge #(.PULSE_CYC(P), .HOLD_CYC(H), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
        .nand_rb_n(nand_rb_n)
    );

    // Bus monitor sampled at the falling clock edge
    int   we_falls = 0, re_falls = 0, we_width = 0, re_width = 0, wrun = 0, rrun = 0;
    logic prev_we = 1'b1, prev_re = 1'b1;
    logic at_cle, at_ale, at_oe, at_ce_n;
    logic [7:0] at_dq;

    always @(negedge clk) begin
        if (prev_we && !nand_we_n) begin
            we_falls++;
            at_cle = nand_cle; at_ale = nand_ale; at_dq = nand_dq_o;
            at_oe = nand_dq_oe; at_ce_n = nand_ce_n;
        end
        if (prev_re && !nand_re_n) begin
            re_falls++;
            at_oe = nand_dq_oe;
        end
        if (!nand_we_n) wrun++;
        else if (!prev_we) begin we_width = wrun; wrun = 0; end
        if (!nand_re_n) rrun++;
        else if (!prev_re) begin re_width = rrun; rrun = 0; end
        prev_we = nand_we_n;
        prev_re = nand_re_n;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic wr, input logic sel, input logic [31:0] wd,
                         output logic [31:0] rd, output int cyc);
        @(negedge clk);
        host_wr = wr; host_sel = sel; host_wdata = wd; host_req = 1'b1;
        cyc = 0;
        #2;
        while (!host_ack && cyc < 50) begin
            @(negedge clk); #2;
            cyc++;
        end
        rd = host_rdata;
        @(posedge clk); #1;
        host_req = 1'b0;
        #1;
        chk("R11 ack single cycle", {31'b0, host_ack}, 32'h0);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int cyc, wf, rf;
        repeat (3) @(negedge clk);
        chk("R1 reset pins", {26'b0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe},
            {26'b0, 6'b111000});
        chk("R1 reset ack", {31'b0, host_ack}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {26'b0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe},
            {26'b0, 6'b111000});

        // R2 / R3 / R4 / R5 / R10 / R11: every byte on each bus-writing code
        for (int o = 0; o < 4; o++) begin
            if (o == 2) continue;
            for (int b = 0; b < 256; b++) begin
                logic ce;
                ce = b[0] ^ b[3];
                wf = we_falls;
                do_op(1'b1, 1'b0, {ce, 3'(o), 4'hA, 8'(b), 16'h5C3F}, rd, cyc);
                chk("R2R3R4 one WE pulse", 32'(we_falls - wf), 32'd1);
                chk("R2R3R4 CLE/ALE/OE", {29'b0, at_cle, at_ale, at_oe},
                    {29'b0, o == 0, o == 1, 1'b1});
                chk("R2 data byte", {24'b0, at_dq}, 32'(b));
                chk("R5 chip enable", {31'b0, at_ce_n}, {31'b0, ~ce});
                chk("R10 WE low width", 32'(we_width), 32'(P));
                chk("R11 bus ack latency", 32'(cyc), 32'(1 + P + H));
            end
        end

        // R6: read mode and one strobe per data read
        wf = we_falls; rf = re_falls;
        do_op(1'b1, 1'b0, {1'b1, 3'd2, 28'h0FF_FFFF}, rd, cyc);
        chk("R6 read select no strobe", 32'((we_falls - wf) + (re_falls - rf)), 32'd0);
        chk("R6 read select immediate", 32'(cyc), 32'd0);
        chk("R5 CE after read select", {31'b0, nand_ce_n}, 32'h0);
        for (int b = 0; b < 256; b++) begin
            nand_dq_i = 8'(b * 37 + 11);
            wf = we_falls; rf = re_falls;
            do_op(1'b0, 1'b1, 32'h0, rd, cyc);
            chk("R6 data read value", rd, {8'h0, 8'(b * 37 + 11), 16'h0});
            chk("R6 one RE pulse", 32'(re_falls - rf), 32'd1);
            chk("R6 no WE, no OE", {31'b0, at_oe}, 32'(we_falls - wf));
            chk("R10 RE low width", 32'(re_width), 32'(P));
            chk("R11 read ack latency", 32'(cyc), 32'(1 + P + H));
        end

        // R8 / R7: unused codes are silent and end read mode
        for (int o = 4; o < 8; o++) begin
            wf = we_falls; rf = re_falls;
            do_op(1'b1, 1'b0, {1'b1, 3'(o), 4'h0, 8'hC3, 16'h0}, rd, cyc);
            chk("R8 unused no strobe", 32'((we_falls - wf) + (re_falls - rf)), 32'd0);
            chk("R8 unused immediate", 32'(cyc), 32'd0);
            nand_dq_i = 8'h99;
            do_op(1'b0, 1'b1, 32'h0, rd, cyc);
            chk("R7 read outside read mode", rd, 32'h0);
            chk("R7 no RE outside read mode", 32'(re_falls - rf), 32'd0);
            chk("R7 immediate ack", 32'(cyc), 32'd0);
            do_op(1'b1, 1'b0, {1'b1, 3'd2, 28'h0}, rd, cyc);
        end
        // R7: a command code also leaves read mode
        do_op(1'b1, 1'b0, {1'b0, 3'd0, 4'h0, 8'h70, 16'h0}, rd, cyc);
        chk("R5 CE released", {31'b0, nand_ce_n}, 32'h1);
        rf = re_falls;
        do_op(1'b0, 1'b1, 32'h0, rd, cyc);
        chk("R7 command ends read mode", rd, 32'h0);
        chk("R7 no RE after command", 32'(re_falls - rf), 32'd0);

        // R9: ready/busy through two flops
        do_op(1'b0, 1'b0, 32'h0, rd, cyc);
        chk("R9 ready status", rd, 32'h0);
        @(negedge clk); nand_rb_n = 1'b0;
        do_op(1'b0, 1'b0, 32'h0, rd, cyc);
        chk("R9 busy after one edge", rd, 32'h0);
        do_op(1'b0, 1'b0, 32'h0, rd, cyc);
        chk("R9 busy after two edges", rd, 32'h0000_8000);
        chk("R9 status immediate", 32'(cyc), 32'd0);
        @(negedge clk); nand_rb_n = 1'b1;
        repeat (3) @(negedge clk);
        do_op(1'b0, 1'b0, 32'h0, rd, cyc);
        chk("R9 ready again", rd, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule